// File: doc/BRIEF.md
# Graphics Virtual-to-Physical Address Translator

This block turns a byte address inside a virtual frame buffer into a physical memory address. It stores only the visible part of each line. The virtual buffer has 1024 lines. Each line is cut into 16-byte blocks. A line is either 192 blocks (3072 bytes) or 256 blocks (4096 bytes) long, as configuration selects. A 1024-entry line table holds one record per line: an enable bit, the first and last visible block, and a signed line offset counted in 16-byte units. Software programs the offsets so that the visible span of each line follows directly after the span of the line before it. The visible pixels of the whole buffer then sit in one contiguous physical area.

The physical area is placed by two configuration fields. A base field picks an 8 MByte aligned region, and a buffer offset field picks the position inside that region. A request that lands on an invisible block, on a disabled line or beyond the last line is not mapped. The block flags it as out of screen and returns a programmable default value in place of an address. Requests enter through a valid/ready handshake, and each response appears one cycle after it is accepted. The line table can be read back through its own port.

Top module: `gvx_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, cfg_err is 0 and the line length is 256 blocks with the 24-bit pixel flag clear.
- R2: With 256-block lines (cfg_blk256=1), the virtual address decodes as line = vaddr[21:12], block = vaddr[11:4], byte = vaddr[3:0].
- R3: With 192-block lines (cfg_blk256=0), line = vaddr / 3072, block = (vaddr mod 3072) / 16, byte = vaddr[3:0].
- R4: For a visible block, rsp_paddr = {base, 23'b0} + buffer offset + (line offset + block) * 16 + byte, taken modulo 2^32, with the line offset signed.
- R5: A block below the line's first block or above its last block gives rsp_oos=1 and rsp_paddr equal to the programmed default value. The first and last blocks themselves are visible.
- R6: A line whose enable bit is 0 gives rsp_oos=1 and the default value for every block.
- R7: With 192-block lines, an address whose line index is 1024 or more gives rsp_oos=1 and the default value.
- R8: cfg_err is 1 exactly when the registered configuration selects both 256-block lines and 24-bit pixels. It changes only in the cycle after a configuration write.
- R9: An accepted request (req_valid and req_ready both high at a clock edge) gives rsp_valid=1 from the next edge. While rsp_valid=1 and rsp_ready=0, the response holds steady and req_ready is 0.
- R10: A table write in one cycle is used by every request accepted at a later edge. The readback port returns the entry at tbl_ridx one cycle after the index is presented.
- R11: A table entry is packed as bit 36 = enable, bits 35:28 = first block, bits 27:20 = last block, bits 19:0 = line offset in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads the configuration fields below |
| cfg_blk256 | input | 1 | 1 selects 256-block lines, 0 selects 192-block lines |
| cfg_bpp24 | input | 1 | Marks the buffer as 24-bit pixels |
| cfg_base | input | 9 | Selects the 8 MByte physical region |
| cfg_bofs | input | 23 | Buffer offset inside the region |
| cfg_dflt | input | 32 | Value returned for out-of-screen requests |
| cfg_err | output | 1 | Illegal line length for 24-bit pixels |
| tbl_we | input | 1 | Line table write strobe |
| tbl_widx | input | 10 | Line table write index |
| tbl_wdata | input | 37 | Line table write entry |
| tbl_ridx | input | 10 | Line table readback index |
| tbl_rdata | output | 37 | Line table readback entry |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 22 | Virtual byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 32 | Physical address or default value |
| rsp_oos | output | 1 | Request fell out of screen |

## Verification
A wrong decode or a stale table read shows up at rsp_paddr in the response to the request that caused it, one cycle after acceptance. A decode error moves the address by a multiple of 16 or by a line stride. A bad bound compare flips rsp_oos on the edge blocks of a line. If the handshake state is wrong, a response appears without a request, or a stalled response changes, or a second request gets in while the first is blocked, all within a cycle or two. A configuration register that latched the wrong value shows at cfg_err, or in every later address, right after the next write.

// File: rtl/gvx_pkg.sv
package gvx_pkg;
  localparam int LINES     = 1024;
  localparam int LINE_W    = $clog2(LINES);
  localparam int BLK_W     = 8;
  localparam int BYTE_W    = 4;
  localparam int BLK_BYTES = 1 << BYTE_W;
  localparam int SHORT_BLKS = 192;
  localparam int STRIDE_S  = SHORT_BLKS * BLK_BYTES;
  localparam int LOFS_W    = 20;
  localparam int VA_W      = LINE_W + BLK_W + BYTE_W;
  localparam int PA_W      = 32;
  localparam int REGION_W  = 23;
  localparam int BASE_W    = PA_W - REGION_W;

  typedef struct packed {
    logic              en;
    logic [BLK_W-1:0]  first;
    logic [BLK_W-1:0]  last;
    logic [LOFS_W-1:0] lofs;
  } line_ent_t;

  localparam int ENT_W = $bits(line_ent_t);
endpackage

// File: rtl/gvx_decode.sv
module gvx_decode import gvx_pkg::*; (
  input  logic              mode256,
  input  logic [VA_W-1:0]   vaddr,
  output logic [LINE_W-1:0] line,
  output logic [BLK_W-1:0]  blk,
  output logic [BYTE_W-1:0] byte_o,
  output logic              oor
);
  localparam int RW = BLK_W + BYTE_W;

  logic [VA_W-1:0] q_s, q_l, q;
  logic [RW-1:0]   r_s, r_l, r;

  always_comb begin
    // short lines: stride is not a power of two, divide by a constant
    q_s = vaddr / VA_W'(STRIDE_S);
    r_s = RW'(vaddr - q_s * VA_W'(STRIDE_S));
    // long lines: plain bit fields
    q_l = VA_W'(vaddr >> RW);
    r_l = vaddr[RW-1:0];
    q   = mode256 ? q_l : q_s;
    r   = mode256 ? r_l : r_s;
    line   = q[LINE_W-1:0];
    oor    = (q >= VA_W'(LINES));
    blk    = r[BYTE_W +: BLK_W];
    byte_o = r[BYTE_W-1:0];
  end
endmodule

// File: rtl/gvx_line_table.sv
module gvx_line_table #(
  parameter int DEPTH = 1024,
  parameter int W     = 37,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic          re_a,
  input  logic [AW-1:0] ridx_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] ridx_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= mem[ridx_a];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[ridx_b];
  end
endmodule

// File: rtl/gvx_compose.sv
module gvx_compose import gvx_pkg::*; (
  input  logic [BASE_W-1:0]   base,
  input  logic [REGION_W-1:0] bofs,
  input  logic [PA_W-1:0]     dflt,
  input  line_ent_t           ent,
  input  logic [BLK_W-1:0]    blk,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                oor,
  output logic [PA_W-1:0]     paddr,
  output logic                oos
);
  logic [PA_W-1:0] span, phys;

  always_comb begin
    oos  = oor || !ent.en || (blk < ent.first) || (blk > ent.last);
    span = {{(PA_W-LOFS_W){ent.lofs[LOFS_W-1]}}, ent.lofs} + PA_W'(blk);
    phys = {base, {REGION_W{1'b0}}} + PA_W'(bofs) + (span << BYTE_W)
         + PA_W'(byte_i);
    paddr = oos ? dflt : phys;
  end
endmodule

// File: rtl/gvx_xlate.sv
module gvx_xlate import gvx_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_blk256,
  input  logic                cfg_bpp24,
  input  logic [BASE_W-1:0]   cfg_base,
  input  logic [REGION_W-1:0] cfg_bofs,
  input  logic [PA_W-1:0]     cfg_dflt,
  output logic                cfg_err,
  input  logic                tbl_we,
  input  logic [LINE_W-1:0]   tbl_widx,
  input  logic [ENT_W-1:0]    tbl_wdata,
  input  logic [LINE_W-1:0]   tbl_ridx,
  output logic [ENT_W-1:0]    tbl_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic                rsp_oos
);
  // configuration registers
  logic                blk256_q, bpp24_q;
  logic [BASE_W-1:0]   base_q;
  logic [REGION_W-1:0] bofs_q;
  logic [PA_W-1:0]     dflt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk256_q <= 1'b1;
      bpp24_q  <= 1'b0;
      base_q   <= '0;
      bofs_q   <= '0;
      dflt_q   <= '0;
    end else if (cfg_we) begin
      blk256_q <= cfg_blk256;
      bpp24_q  <= cfg_bpp24;
      base_q   <= cfg_base;
      bofs_q   <= cfg_bofs;
      dflt_q   <= cfg_dflt;
    end
  end

  assign cfg_err = blk256_q & bpp24_q;

  // request decode
  logic [LINE_W-1:0] d_line;
  logic [BLK_W-1:0]  d_blk;
  logic [BYTE_W-1:0] d_byte;
  logic              d_oor;

  gvx_decode u_dec (
    .mode256 (blk256_q),
    .vaddr   (req_vaddr),
    .line    (d_line),
    .blk     (d_blk),
    .byte_o  (d_byte),
    .oor     (d_oor)
  );

  // handshake: single response slot
  logic acc;
  logic vld_q;

  assign req_ready = !vld_q || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst)           vld_q <= 1'b0;
    else if (acc)      vld_q <= 1'b1;
    else if (rsp_ready) vld_q <= 1'b0;
  end

  // line table, read on acceptance
  logic [ENT_W-1:0] ent_raw;

  gvx_line_table #(.DEPTH(LINES), .W(ENT_W)) u_tbl (
    .clk     (clk),
    .we      (tbl_we),
    .widx    (tbl_widx),
    .wdata   (tbl_wdata),
    .re_a    (acc),
    .ridx_a  (d_line),
    .rdata_a (ent_raw),
    .ridx_b  (tbl_ridx),
    .rdata_b (tbl_rdata)
  );

  // request fields held beside the table read
  logic [BLK_W-1:0]  blk_q;
  logic [BYTE_W-1:0] byte_q;
  logic              oor_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= '0;
      byte_q <= '0;
      oor_q  <= 1'b0;
    end else if (acc) begin
      blk_q  <= d_blk;
      byte_q <= d_byte;
      oor_q  <= d_oor;
    end
  end

  gvx_compose u_cmp (
    .base   (base_q),
    .bofs   (bofs_q),
    .dflt   (dflt_q),
    .ent    (line_ent_t'(ent_raw)),
    .blk    (blk_q),
    .byte_i (byte_q),
    .oor    (oor_q),
    .paddr  (rsp_paddr),
    .oos    (rsp_oos)
  );

  assign rsp_valid = vld_q;
endmodule

// File: rtl/gvx_checker.sv
module gvx_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_oos,
  input logic        cfg_we,
  input logic        cfg_blk256,
  input logic        cfg_bpp24,
  input logic        cfg_err
);
  p_rsp_after_acc_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_oos)));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_rsp_origin_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  p_cfg_err_load_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst)) |-> (cfg_err == $past(cfg_blk256 && cfg_bpp24)));

  p_cfg_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && !$past(rst)) |-> $stable(cfg_err));
endmodule

bind gvx_xlate gvx_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_oos    (rsp_oos),
  .cfg_we     (cfg_we),
  .cfg_blk256 (cfg_blk256),
  .cfg_bpp24  (cfg_bpp24),
  .cfg_err    (cfg_err)
);

// File: tb/gvx_xlate_bench.sv
`timescale 1ns/1ps
module gvx_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_blk256 = 0, cfg_bpp24 = 0;
  logic [8:0]  cfg_base = '0;
  logic [22:0] cfg_bofs = '0;
  logic [31:0] cfg_dflt = '0;
  logic        cfg_err;
  logic        tbl_we = 0;
  logic [9:0]  tbl_widx = '0, tbl_ridx = '0;
  logic [36:0] tbl_wdata = '0, tbl_rdata;
  logic        req_valid = 0, req_ready;
  logic [21:0] req_vaddr = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_oos;
  logic [31:0] rsp_paddr;

  always #2.5 clk = ~clk;

  gvx_xlate u_gvx_xlate (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_blk256(cfg_blk256), .cfg_bpp24(cfg_bpp24),
    .cfg_base(cfg_base), .cfg_bofs(cfg_bofs), .cfg_dflt(cfg_dflt), .cfg_err(cfg_err),
    .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
    .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_oos(rsp_oos)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench copy of the configuration, used by the reference formula
  logic [8:0]  m_base;
  logic [22:0] m_bofs;
  logic [31:0] m_dflt;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [36:0] mk_ent(input logic en, input int first, input int last,
                                         input int lofs);
    logic [19:0] l;
    l = 20'(lofs);
    return {en, 8'(first), 8'(last), l};
  endfunction

  // R4 reference
  function automatic logic [31:0] ref_pa(input int lofs, input int blk, input int byt);
    logic [31:0] s;
    s = 32'(lofs + blk);
    return {m_base, 23'd0} + 32'(m_bofs) + (s << 4) + 32'(byt);
  endfunction

  task automatic set_cfg(input logic b256, input logic b24, input logic [8:0] base,
                         input logic [22:0] bofs, input logic [31:0] dflt);
    @(negedge clk);
    cfg_we = 1; cfg_blk256 = b256; cfg_bpp24 = b24;
    cfg_base = base; cfg_bofs = bofs; cfg_dflt = dflt;
    m_base = base; m_bofs = bofs; m_dflt = dflt;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_ent(input int idx, input logic [36:0] e);
    @(negedge clk);
    tbl_we = 1; tbl_widx = 10'(idx); tbl_wdata = e;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic xlate(input string tag, input logic [21:0] va, input logic exp_oos,
                       input logic [31:0] exp_pa);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " oos"}, 64'(rsp_oos), 64'(exp_oos));
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_oos ? m_dflt : exp_pa));
  endtask

  function automatic logic [21:0] va256(input int line, input int blk, input int byt);
    return {10'(line), 8'(blk), 4'(byt)};
  endfunction

  function automatic logic [21:0] va192(input int line, input int blk, input int byt);
    return 22'(line * 3072 + blk * 16 + byt);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 cfg_err", 64'(cfg_err), 64'd0);
  endtask

  task automatic t_mode256;
    set_cfg(1, 0, 9'h005, 23'h001000, 32'hDEAD_BEEF);
    wr_ent(0, mk_ent(1, 5, 9, -5));
    wr_ent(3, mk_ent(1, 10, 200, 100));
    wr_ent(1023, mk_ent(1, 0, 255, 1000));
    xlate("R2 R4 line3", va256(3, 50, 7), 0, ref_pa(100, 50, 7));
    xlate("R4 negative offset", va256(0, 5, 0), 0, ref_pa(-5, 5, 0));
    xlate("R2 last address", 22'h3FFFFF, 0, ref_pa(1000, 255, 15));
  endtask

  task automatic t_bounds;
    xlate("R5 first block", va256(3, 10, 1), 0, ref_pa(100, 10, 1));
    xlate("R5 below first", va256(3, 9, 1), 1, 32'h0);
    xlate("R5 last block", va256(3, 200, 2), 0, ref_pa(100, 200, 2));
    xlate("R5 above last", va256(3, 201, 2), 1, 32'h0);
  endtask

  task automatic t_disabled;
    wr_ent(7, mk_ent(0, 0, 255, 0));
    xlate("R6 disabled line", va256(7, 40, 0), 1, 32'h0);
  endtask

  task automatic t_mode192;
    set_cfg(0, 1, 9'h1F0, 23'h7FFFF0, 32'h1234_5678);
    chk("R8 192 with 24bpp", 64'(cfg_err), 64'd0);
    wr_ent(5, mk_ent(1, 0, 191, 300));
    wr_ent(2, mk_ent(1, 20, 150, -20));
    xlate("R3 line5 end", va192(5, 191, 15), 0, ref_pa(300, 191, 15));
    xlate("R3 line2 mid", va192(2, 100, 3), 0, ref_pa(-20, 100, 3));
    xlate("R3 line1023", va192(1023, 2, 1), 0, ref_pa(1000, 2, 1));
  endtask

  task automatic t_range192;
    xlate("R7 line 1024", va192(1024, 1, 0), 1, 32'h0);
    xlate("R7 top address", 22'h3FFFFF, 1, 32'h0);
  endtask

  task automatic t_cfg_err;
    set_cfg(1, 1, 9'h0, 23'h0, 32'h0);
    chk("R8 256 with 24bpp", 64'(cfg_err), 64'd1);
    set_cfg(1, 0, 9'h005, 23'h001000, 32'hDEAD_BEEF);
    chk("R8 256 without 24bpp", 64'(cfg_err), 64'd0);
  endtask

  task automatic t_stall;
    logic [31:0] ea, eb;
    ea = ref_pa(100, 60, 4);
    eb = ref_pa(-5, 9, 8);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = va256(3, 60, 4);
    @(posedge clk);
    @(negedge clk);
    req_vaddr = va256(0, 9, 8);
    chk("R9 valid after accept", 64'(rsp_valid), 64'd1);
    chk("R9 ready low when blocked", 64'(req_ready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held paddr", 64'(rsp_paddr), 64'(ea));
      chk("R9 still valid", 64'(rsp_valid), 64'd1);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R9 second valid", 64'(rsp_valid), 64'd1);
    chk("R9 second paddr", 64'(rsp_paddr), 64'(eb));
    @(negedge clk);
    chk("R9 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_update;
    wr_ent(3, mk_ent(1, 0, 255, -3));
    xlate("R10 rewritten line", va256(3, 60, 4), 0, ref_pa(-3, 60, 4));
    @(negedge clk);
    tbl_ridx = 10'd3;
    @(negedge clk);
    chk("R10 R11 readback line3", 64'(tbl_rdata), 64'(mk_ent(1, 0, 255, -3)));
    tbl_ridx = 10'd7;
    @(negedge clk);
    chk("R10 R11 readback line7", 64'(tbl_rdata), 64'(mk_ent(0, 0, 255, 0)));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_base = '0; m_bofs = '0; m_dflt = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset;
    t_mode256;
    t_bounds;
    t_disabled;
    t_cfg_err;
    t_stall;
    t_update;
    t_mode192;
    t_range192;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule